// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire management interface of an Ethernet PHY. Software loads one 32-bit frame word. The word carries the start code, the opcode, the PHY address, the register address, the turnaround code and 16 data bits. While idle the block accepts the word and raises `busy`. It then generates the management clock `mdc` from the system clock. On the data line it sends an optional 32-bit all-ones preamble, followed by the frame word with the most significant bit first. When the transfer ends it raises a sticky completion flag.

Three settings come in as configuration inputs and are captured when a word is accepted:
- the clock divider,
- the number of system clocks that the data line output trails each falling edge of `mdc`,
- preamble suppression.

On a read the block releases the data line for the second turnaround bit and the 16 data bits. It samples the PHY's reply on each rising edge of `mdc` and shifts the reply into the low half of the frame register, where software reads it back.

Top module: `mdio_master`

## Requirements
- R1: The frame word is sent most significant bit first, one bit per `mdc` period, with bits [31:30] start, [29:28] opcode, [27:23] PHY address, [22:18] register address, [17:16] turnaround and [15:0] data. After a write the frame register reads back the word as loaded.
- R2: With `pre_off` = 0, 32 one-bits with `mdio_oe` = 1 come before the frame, so a transfer lasts 64 `mdc` periods. With `pre_off` = 1 there is no preamble and a transfer lasts 32 periods.
- R3: The `mdc` period is 2*(`div_sel`+1) system clocks. `mdc` is low for the first half of each bit and high for the second. Data changes only after a falling edge. `mdc` stays low while the block is idle.
- R4: When `div_sel` = 0, a frame write is ignored, `busy` stays low, `mdc` stays low and the frame register keeps its value.
- R5: `mdio_o` and `mdio_oe` follow the internally driven bit value with a delay of exactly `hold_sel` system clocks. A value of 0 means no delay.
- R6: When the opcode is 10 (read), `mdio_oe` is 0 from frame bit 16 through the end of the frame. When the opcode is 01 (write), all 32 frame bits are driven. Whenever `mdio_oe` is 0, `mdio_o` is 0.
- R7: On a read, `mdio_i` is sampled in the last system clock before each rising edge of `mdc` during frame bits 15..0. The sampled bits are shifted into frame register bits [15:0], first sample into bit 15. Bits [31:16] are unchanged.
- R8: `done` goes high in the first cycle after the last bit of any frame. It stays high until `done_clr` is asserted. If a completion and `done_clr` arrive together, `done` is set.
- R9: `busy` is high from the cycle after an accepted write to the end of the last bit. A frame write while `busy` is high has no effect on the frame register or on the line.
- R10: Changes to `div_sel`, `hold_sel` or `pre_off` while `busy` is high do not change the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_we | input | 1 | Frame register write strobe |
| frame_wdata | input | 32 | Frame word to send |
| div_sel | input | 6 | `mdc` divider; half period is `div_sel`+1 clocks |
| pre_off | input | 1 | 1 suppresses the preamble |
| hold_sel | input | 3 | Output delay after the `mdc` falling edge, in clocks |
| done_clr | input | 1 | Clears the completion flag |
| mdio_i | input | 1 | Data line input from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| frame_rdata | output | 32 | Frame register, with read data in [15:0] after a read |

## Verification
A reference model predicts `mdc`, the delayed line drive, `busy` and `done` on every clock. It is compared across several combinations of divider, hold and preamble.
- A design that sampled on the wrong `mdc` edge, or shifted the reply in reverse order, would return a corrupted read word.
- A design that released the line one bit early or late would show a mismatch on `mdio_oe` at the turnaround.
- The bench writes to the frame register while a transfer runs, and changes the divider mid-transfer. A design that accepted either would mix the new word or the new timing into the frame.
- A zero divider must leave the block idle. A design that started anyway would hang with `mdc` stuck or run a frame nobody asked for.
- The bench checks that `done` stays high until it is cleared. A flag that dropped on its own would lose completions.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int FRAME_W  = 32;
    localparam int PRE_LEN  = 32;
    localparam int DATA_W   = 16;
    localparam int IDX_W    = $clog2(PRE_LEN + FRAME_W + 1);
    localparam int POS_W    = $clog2(FRAME_W);
    localparam int OP_MSB   = 29;
    localparam int REL_POS  = FRAME_W - DATA_W - 1;   // second turnaround bit
    localparam int CAP_POS  = FRAME_W - DATA_W;       // first data bit
    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [1:0] OP_RD = 2'b10;

    typedef struct packed {
        logic             busy;
        logic             npre;
        logic [IDX_W-1:0] idx;
        logic             o;
        logic             oe;
    } seq_st_t;

    // Drive pair {oe, o} for serial position idx of a transfer
    function automatic logic [1:0] frame_drive(input logic [FRAME_W-1:0] w,
                                               input logic npre,
                                               input logic [IDX_W-1:0] idx);
        logic [1:0]       res;
        logic [IDX_W-1:0] f;
        logic [POS_W-1:0] pos;
        logic             rd;
        rd  = (w[OP_MSB -: 2] == OP_RD);
        f   = npre ? idx : idx - IDX_W'(PRE_LEN);
        pos = POS_W'(FRAME_W - 1) - f[POS_W-1:0];
        if (!npre && idx < IDX_W'(PRE_LEN))
            res = 2'b11;
        else if (rd && f >= IDX_W'(REL_POS))
            res = 2'b00;
        else
            res = {1'b1, w[pos]};
        return res;
    endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
`timescale 1ns/1ps
module mdio_clkdiv #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_st_t;

    div_st_t st_q, st_d;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = run && (st_q.cnt == div_val);
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc       = st_q.mdc;
    assign rise_tick = wrap && !st_q.mdc;
    assign fall_tick = wrap &&  st_q.mdc;
endmodule

// File: rtl/mdio_hold.sv
`timescale 1ns/1ps
module mdio_hold #(
    parameter int HOLD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOLD_W-1:0] sel,
    input  logic              o_in,
    input  logic              oe_in,
    output logic              o_out,
    output logic              oe_out
);
    localparam int DEPTH = (1 << HOLD_W) - 1;

    logic [1:0] tap [0:DEPTH];

    assign tap[0] = {oe_in, o_in};

    for (genvar k = 1; k <= DEPTH; k++) begin : g_stage
        logic [1:0] stage_d, stage_q;
        always_comb stage_d = tap[k-1];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= stage_d;
        end
        assign tap[k] = stage_q;
    end

    assign {oe_out, o_out} = tap[sel];
endmodule

// File: rtl/mdio_seq.sv
`timescale 1ns/1ps
module mdio_seq
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               pre_off,
    input  logic [FRAME_W-1:0] word,
    input  logic               rise_tick,
    input  logic               fall_tick,
    output logic               busy,
    output logic               o,
    output logic               oe,
    output logic               done_pulse,
    output logic               cap_en
);
    seq_st_t          st_q, st_d;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] fidx;
    logic [IDX_W-1:0] nxt_idx;
    logic             in_frame;
    logic             is_read;

    always_comb begin
        last_idx   = st_q.npre ? IDX_W'(FRAME_W - 1) : IDX_W'(PRE_LEN + FRAME_W - 1);
        fidx       = st_q.npre ? st_q.idx : st_q.idx - IDX_W'(PRE_LEN);
        in_frame   = st_q.npre || (st_q.idx >= IDX_W'(PRE_LEN));
        is_read    = (word[OP_MSB -: 2] == OP_RD);
        nxt_idx    = st_q.idx + 1'b1;
        done_pulse = st_q.busy && fall_tick && (st_q.idx == last_idx);
        cap_en     = st_q.busy && rise_tick && is_read && in_frame
                     && (fidx >= IDX_W'(CAP_POS));

        st_d = st_q;
        if (start) begin
            st_d.busy          = 1'b1;
            st_d.npre          = pre_off;
            st_d.idx           = '0;
            {st_d.oe, st_d.o}  = frame_drive(word, pre_off, '0);
        end else if (done_pulse) begin
            st_d.busy = 1'b0;
            st_d.idx  = '0;
            st_d.o    = 1'b0;
            st_d.oe   = 1'b0;
        end else if (st_q.busy && fall_tick) begin
            st_d.idx           = nxt_idx;
            {st_d.oe, st_d.o}  = frame_drive(word, st_q.npre, nxt_idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign o    = st_q.o;
    assign oe   = st_q.oe;
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W  = 6,
    parameter int HOLD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_we,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic [DIV_W-1:0]   div_sel,
    input  logic               pre_off,
    input  logic [HOLD_W-1:0]  hold_sel,
    input  logic               done_clr,
    input  logic               mdio_i,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               busy,
    output logic               done,
    output logic [FRAME_W-1:0] frame_rdata
);
    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [DIV_W-1:0]   div;
        logic [HOLD_W-1:0]  hold;
        logic               done;
    } top_st_t;

    top_st_t            st_q, st_d;
    logic               start;
    logic               seq_busy;
    logic               seq_o, seq_oe;
    logic               done_pulse, cap_en;
    logic               rise_tick, fall_tick;
    logic [FRAME_W-1:0] seq_word;

    always_comb begin
        start    = frame_we && !seq_busy && (div_sel != '0);
        seq_word = start ? frame_wdata : st_q.frame;

        st_d = st_q;
        if (start) begin
            st_d.frame = frame_wdata;
            st_d.div   = div_sel;
            st_d.hold  = hold_sel;
        end else if (cap_en) begin
            st_d.frame[DATA_W-1:0] = {st_q.frame[DATA_W-2:0], mdio_i};
        end

        if (done_pulse)    st_d.done = 1'b1;
        else if (done_clr) st_d.done = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mdio_clkdiv #(.DIV_W(DIV_W)) clkdiv_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (seq_busy),
        .div_val   (st_q.div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .pre_off    (pre_off),
        .word       (seq_word),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .busy       (seq_busy),
        .o          (seq_o),
        .oe         (seq_oe),
        .done_pulse (done_pulse),
        .cap_en     (cap_en)
    );

    mdio_hold #(.HOLD_W(HOLD_W)) hold_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (st_q.hold),
        .o_in   (seq_o),
        .oe_in  (seq_oe),
        .o_out  (mdio_o),
        .oe_out (mdio_oe)
    );

    assign busy        = seq_busy;
    assign done        = st_q.done;
    assign frame_rdata = st_q.frame;
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk #(
    parameter int DIV_W  = 6,
    parameter int HOLD_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_we,
    input logic [31:0]       frame_wdata,
    input logic [DIV_W-1:0]  div_sel,
    input logic              pre_off,
    input logic [HOLD_W-1:0] hold_sel,
    input logic              done_clr,
    input logic              mdio_i,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              busy,
    input logic              done,
    input logic [31:0]       frame_rdata
);
    assert_idle_mdc_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_mdc_rise_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy);

    assert_zero_div_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_we && !busy && div_sel == '0) |=> !busy);

    assert_released_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mdio_oe |-> !mdio_o);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done);

    assert_done_on_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_start_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_we && !busy && div_sel != '0) |=> busy);

    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && frame_we) |=> $stable(frame_rdata[31:16]));
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) chk_i (.*);

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
    localparam int DIV_W  = 6;
    localparam int HOLD_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_we = 1'b0;
    logic [31:0]       frame_wdata = '0;
    logic [DIV_W-1:0]  div_sel = '0;
    logic              pre_off = 1'b0;
    logic [HOLD_W-1:0] hold_sel = '0;
    logic              done_clr = 1'b0;
    logic              mdio_i = 1'b1;
    logic              mdc, mdio_o, mdio_oe, busy, done;
    logic [31:0]       frame_rdata;
    logic [15:0]       phy_val = '0;

    typedef struct packed {
        logic mdc;
        logic o;
        logic oe;
        logic busy;
        logic last;
        logic phy;
    } exp_t;

    exp_t q[$];
    logic m_done = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;
    int   busy_cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    mdio_master #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_we(frame_we), .frame_wdata(frame_wdata),
        .div_sel(div_sel), .pre_off(pre_off), .hold_sel(hold_sel), .done_clr(done_clr),
        .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .busy(busy), .done(done), .frame_rdata(frame_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected {oe, o} for serial bit b of a transfer (from R1, R2, R6)
    function automatic logic [1:0] bit_drive(input logic [31:0] w, input bit npre, input int b);
        int  f;
        bit  rd;
        rd = (w[29:28] == 2'b10);
        if (!npre && b < 32) return 2'b11;
        f = npre ? b : b - 32;
        if (rd && f >= 15) return 2'b00;
        return {1'b1, w[31-f]};
    endfunction

    // Queue one expected record per clock for a whole transfer
    function automatic void push_frame(input logic [31:0] w, input bit npre, input int s,
                                       input int h, input logic [15:0] pv);
        int nb, per, len;
        bit rd;
        nb  = npre ? 32 : 64;
        per = 2 * s + 2;
        len = nb * per;
        rd  = (w[29:28] == 2'b10);
        for (int j = 0; j < len + h; j++) begin
            exp_t e;
            int   jd, f;
            jd     = j - h;
            e      = '0;
            e.mdc  = (j < len) && ((j % per) > s);
            e.busy = (j < len);
            e.last = (j == len - 1);
            if (jd >= 0 && jd < len) {e.oe, e.o} = bit_drive(w, npre, jd / per);
            e.phy = 1'b1;
            if (j < len && rd) begin
                f = (j / per) - (npre ? 0 : 32);
                if (f == 15) e.phy = 1'b0;
                if (f >= 16 && f <= 31) e.phy = pv[31-f];
            end
            q.push_back(e);
        end
    endfunction

    // Reference model and per-clock comparison, away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (!rst_n) begin
            m_done = 1'b0;
            q.delete();
        end else begin
            if (q.size() > 0) e = q.pop_front();
            else begin
                e = '0;
                e.phy = 1'b1;
            end
            chk(mdc === e.mdc,      "R3 mdc",     32'(mdc),     32'(e.mdc));
            chk(mdio_oe === e.oe,   "R6 mdio_oe", 32'(mdio_oe), 32'(e.oe));
            chk(mdio_o === e.o,     "R5 mdio_o",  32'(mdio_o),  32'(e.o));
            chk(busy === e.busy,    "R9 busy",    32'(busy),    32'(e.busy));
            chk(done === m_done,    "R8 done",    32'(done),    32'(m_done));
            if (busy) busy_cycles++;
            mdio_i = e.phy;
            if (e.last)        m_done = 1'b1;
            else if (done_clr) m_done = 1'b0;
            if (frame_we && !e.busy && div_sel != '0)
                push_frame(frame_wdata, pre_off, int'(div_sel), int'(hold_sel), phy_val);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic xfer(input logic [31:0] w, input int s, input bit npre, input int h,
                        input logic [15:0] pv, input int poke, input string tag);
        logic [31:0] expw;
        tick();
        frame_wdata = w;
        div_sel     = DIV_W'(s);
        pre_off     = npre;
        hold_sel    = HOLD_W'(h);
        phy_val     = pv;
        busy_cycles = 0;
        frame_we    = 1'b1;
        tick();
        frame_we = 1'b0;
        if (poke != 0) begin
            repeat (20) tick();
            if (poke == 1) begin
                frame_wdata = ~w;     // R9: must be ignored while busy
                frame_we    = 1'b1;
                tick();
                frame_we    = 1'b0;
            end else begin
                div_sel  = DIV_W'(s + 3);   // R10: must not alter running frame
                hold_sel = HOLD_W'(h + 1);
                pre_off  = ~npre;
            end
        end
        while (q.size() != 0) tick();
        repeat (3) tick();
        expw = (w[29:28] == 2'b10) ? {w[31:16], pv} : w;
        chk(frame_rdata === expw, {tag, " readback"}, frame_rdata, expw);
        if (npre) chk(busy_cycles == 32 * (2 * s + 2), "R2 frame length", busy_cycles, 32 * (2 * s + 2));
        else      chk(busy_cycles == 64 * (2 * s + 2), "R3 frame length", busy_cycles, 64 * (2 * s + 2));
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL R9 watchdog expired act=%0d exp=%0d", n_chk, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] wr_word, rd_word, keep;
        wr_word = {2'b01, 2'b01, 5'h11, 5'h03, 2'b10, 16'hA5C3};
        rd_word = {2'b01, 2'b10, 5'h05, 5'h1E, 2'b10, 16'h0000};

        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // reset state
        chk(frame_rdata === 32'h0, "R1 reset frame", frame_rdata, 32'h0);
        chk(busy === 1'b0, "R9 reset busy", 32'(busy), 0);
        chk(done === 1'b0, "R8 reset done", 32'(done), 0);
        chk(mdc === 1'b0, "R3 reset mdc", 32'(mdc), 0);
        chk(mdio_oe === 1'b0, "R6 reset oe", 32'(mdio_oe), 0);

        // R1 / R2: write with preamble, no hold
        xfer(wr_word, 2, 1'b0, 0, 16'h0, 0, "R1");

        // R8: flag stays until cleared
        repeat (5) tick();
        chk(done === 1'b1, "R8 sticky", 32'(done), 1);
        done_clr = 1'b1;
        tick();
        done_clr = 1'b0;
        chk(done === 1'b0, "R8 clear", 32'(done), 0);

        // R7: read without preamble, hold 2
        xfer(rd_word, 1, 1'b1, 2, 16'h3C96, 0, "R7");

        // R5: long hold with slower clock
        xfer({2'b01, 2'b01, 5'h1F, 5'h00, 2'b10, 16'h5A0F}, 5, 1'b0, 7, 16'h0, 0, "R5");

        // R9: write attempt in the middle of a read with preamble
        xfer(rd_word ^ 32'h07FC_0000, 1, 1'b0, 1, 16'h8001, 1, "R9");

        // R10: config changes mid-transfer, no preamble
        xfer({2'b01, 2'b01, 5'h02, 5'h11, 2'b10, 16'hFFFF}, 2, 1'b1, 3, 16'h0, 2, "R10");

        // R6: read with all-zero reply
        xfer(rd_word, 3, 1'b1, 0, 16'h0000, 0, "R6");

        // R4: divider zero blocks any start
        keep = frame_rdata;
        tick();
        div_sel     = '0;
        frame_wdata = wr_word;
        frame_we    = 1'b1;
        tick();
        frame_we = 1'b0;
        repeat (10) tick();
        chk(busy === 1'b0, "R4 busy", 32'(busy), 0);
        chk(mdc === 1'b0, "R4 mdc", 32'(mdc), 0);
        chk(frame_rdata === keep, "R4 frame kept", frame_rdata, keep);

        // R8: clear with no completion pending keeps flag low
        done_clr = 1'b1;
        tick();
        done_clr = 1'b0;
        repeat (4) tick();
        chk(done === 1'b0, "R8 cleared idle", 32'(done), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule